// File: doc/BRIEF.md
# Line-Counted Exposure Event Timer

This block places the exposure events of an image sensor frame on a grid of line periods. A frame-start pulse opens a frame. After that, each line tick advances a single saturating line counter. The counter drives five registered outputs:

- the pixel reset level;
- two optional extra reset pulses for multi-slope exposure;
- the frame-transfer pulse that closes integration;
- the calibration strobe for the gain stage.

Each event is programmed as a line count. It fires once the counter has advanced by that count minus one. The timing values, the slope enables and the calibration mode are captured at frame start, so software may rewrite them while a frame is in flight without disturbing that frame. The line tick comes from the line-time generator, which sits outside this block. One line period is the row overhead plus the pixel count times the clock period.

Top module: `expt_line_timer`

## Requirements
- R1: Two cycles after a frame-start pulse, `pix_reset_o` goes high. It falls two cycles after the line tick that brings the line count to (reset length − 1). It therefore stays high for (reset length − 1) line periods.
- R2: Any timer or reset-length value below 2 acts as 2. An event programmed with 0 or 1 fires on the first line tick, and a reset length of 0 or 1 holds reset for exactly one line.
- R3: With the dual-slope enable set, `slope2_o` is high for exactly one clock cycle. That cycle comes two cycles after the line tick that brings the line count to (second-reset value − 1).
- R4: With the dual-slope enable clear, `slope2_o` stays low whatever the second-reset value is. The third-reset pulse behaves the same way with the triple-slope enable clear.
- R5: With the triple-slope enable set, `slope3_o` is high for one clock cycle. That cycle comes two cycles after the line tick that brings the line count to (third-reset value − 1). This enable is independent of the dual-slope enable.
- R6: `xfer_o` is high for one clock cycle, two cycles after the line tick that brings the line count to (frame-transfer value − 1). It is not gated by any enable.
- R7: With `cal_every_line_i` = 1, `cal_strobe_o` pulses for one cycle two cycles after frame start. It also pulses two cycles after every line tick counted within the frame.
- R8: With `cal_every_line_i` = 0, `cal_strobe_o` pulses only two cycles after frame start.
- R9: All timing values, both enables and the calibration mode are sampled on the frame-start cycle only. Changing them mid-frame has no effect until the next frame start.
- R10: The line count stops at 4095 and does not wrap. Further line ticks raise no event, and an event programmed at 4095 fires once, on line count 4094.
- R11: After `rst`, and before the first frame start, all outputs are low and line ticks are ignored. A frame start on the same cycle as a line tick clears the count, and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that opens a frame |
| line_tick | input | 1 | One-cycle pulse per line period |
| reset_len_i | input | 12 | Reset length in lines (+1) |
| slope2_at_i | input | 12 | Second reset position in lines (+1) |
| slope3_at_i | input | 12 | Third reset position in lines (+1) |
| xfer_at_i | input | 12 | Frame transfer position in lines (+1) |
| dual_en_i | input | 1 | Enables the second reset pulse |
| triple_en_i | input | 1 | Enables the third reset pulse |
| cal_every_line_i | input | 1 | 1: calibrate each line, 0: once per frame |
| pix_reset_o | output | 1 | Pixel reset level |
| slope2_o | output | 1 | Second reset pulse |
| slope3_o | output | 1 | Third reset pulse |
| xfer_o | output | 1 | Frame transfer pulse |
| cal_strobe_o | output | 1 | Gain-stage calibration strobe |

## Verification
Saturation of the line counter is the hardest state to reach. It needs more than four thousand counted lines inside one frame, with the reset length and the transfer timer both at 4095. The stimulus therefore runs one long frame with a line tick on every other clock. It then keeps ticking past the limit to confirm that the late events fire exactly once and nothing wraps. Mid-frame register rewrites and a reset issued in the middle of a frame are driven as separate phases.

// File: rtl/expt_pkg.sv
package expt_pkg;
  localparam int N_EV      = 3;
  localparam int EV_SLOPE2 = 0;
  localparam int EV_SLOPE3 = 1;
  localparam int EV_XFER   = 2;
endpackage

// File: rtl/expt_cfg_latch.sv
module expt_cfg_latch
  import expt_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [CW-1:0]            reset_len_i,
  input  logic [CW-1:0]            slope2_at_i,
  input  logic [CW-1:0]            slope3_at_i,
  input  logic [CW-1:0]            xfer_at_i,
  input  logic                     dual_en_i,
  input  logic                     triple_en_i,
  input  logic                     cal_every_line_i,
  output logic [CW-1:0]            len_l,
  output logic [N_EV-1:0][CW-1:0]  tgt_l,
  output logic [N_EV-1:0]          en_l,
  output logic                     mode_l
);
  localparam logic [CW-1:0] FLOOR = CW'(2);

  logic [N_EV-1:0][CW-1:0] raw_tgt;
  logic [N_EV-1:0]         raw_en;

  always_comb begin
    raw_tgt[EV_SLOPE2] = slope2_at_i;
    raw_tgt[EV_SLOPE3] = slope3_at_i;
    raw_tgt[EV_XFER]   = xfer_at_i;
    raw_en[EV_SLOPE2]  = dual_en_i;
    raw_en[EV_SLOPE3]  = triple_en_i;
    raw_en[EV_XFER]    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_l  <= FLOOR;
      mode_l <= 1'b1;
    end else if (load) begin
      len_l  <= (reset_len_i < FLOOR) ? FLOOR : reset_len_i;
      mode_l <= cal_every_line_i;
    end
  end

  for (genvar g = 0; g < N_EV; g++) begin : g_ev_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        tgt_l[g] <= FLOOR;
        en_l[g]  <= 1'b0;
      end else if (load) begin
        tgt_l[g] <= (raw_tgt[g] < FLOOR) ? FLOOR : raw_tgt[g];
        en_l[g]  <= raw_en[g];
      end
    end
  end
endmodule

// File: rtl/expt_line_counter.sv
module expt_line_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          line_tick,
  output logic [CW-1:0] cnt,
  output logic          active,
  output logic          line_q,
  output logic          fs_q
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
      line_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      fs_q <= frame_start;
      if (frame_start) begin
        cnt    <= '0;
        active <= 1'b1;
        line_q <= 1'b0;
      end else if (line_tick && active) begin
        cnt    <= (cnt == CMAX) ? cnt : cnt + ONE;
        line_q <= 1'b1;
      end else begin
        line_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/expt_event_fire.sv
module expt_event_fire #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] target,
  input  logic [CW-1:0] cnt,
  input  logic          line_q,
  output logic          pulse_q
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] fire_at;
  assign fire_at = target - ONE;

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= en && line_q && (cnt == fire_at);
  end
endmodule

// File: rtl/expt_line_timer.sv
module expt_line_timer
  import expt_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          line_tick,
  input  logic [CW-1:0] reset_len_i,
  input  logic [CW-1:0] slope2_at_i,
  input  logic [CW-1:0] slope3_at_i,
  input  logic [CW-1:0] xfer_at_i,
  input  logic          dual_en_i,
  input  logic          triple_en_i,
  input  logic          cal_every_line_i,
  output logic          pix_reset_o,
  output logic          slope2_o,
  output logic          slope3_o,
  output logic          xfer_o,
  output logic          cal_strobe_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0]           len_l;
  logic [N_EV-1:0][CW-1:0] tgt_l;
  logic [N_EV-1:0]         en_l;
  logic                    mode_l;
  logic [CW-1:0]           cnt_w;
  logic                    act_w;
  logic                    line_w;
  logic                    fs_w;
  logic [N_EV-1:0]         pulse_w;
  logic                    reset_q;
  logic                    cal_q;

  expt_cfg_latch #(.CW(CW)) cfg_i (
    .clk(clk), .rst(rst), .load(frame_start),
    .reset_len_i(reset_len_i), .slope2_at_i(slope2_at_i),
    .slope3_at_i(slope3_at_i), .xfer_at_i(xfer_at_i),
    .dual_en_i(dual_en_i), .triple_en_i(triple_en_i),
    .cal_every_line_i(cal_every_line_i),
    .len_l(len_l), .tgt_l(tgt_l), .en_l(en_l), .mode_l(mode_l)
  );

  expt_line_counter #(.CW(CW)) cnt_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_tick(line_tick),
    .cnt(cnt_w), .active(act_w), .line_q(line_w), .fs_q(fs_w)
  );

  for (genvar g = 0; g < N_EV; g++) begin : g_ev
    expt_event_fire #(.CW(CW)) fire_i (
      .clk(clk), .rst(rst), .en(en_l[g]), .target(tgt_l[g]),
      .cnt(cnt_w), .line_q(line_w), .pulse_q(pulse_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_q <= 1'b0;
      cal_q   <= 1'b0;
    end else begin
      reset_q <= act_w && (cnt_w < (len_l - ONE));
      cal_q   <= fs_w || (mode_l && line_w);
    end
  end

  assign pix_reset_o  = reset_q;
  assign slope2_o     = pulse_w[EV_SLOPE2];
  assign slope3_o     = pulse_w[EV_SLOPE3];
  assign xfer_o       = pulse_w[EV_XFER];
  assign cal_strobe_o = cal_q;
endmodule

// File: rtl/expt_line_timer_chk.sv
module expt_line_timer_chk #(
  parameter int CW   = 12,
  parameter int NE   = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start,
  input logic          pix_reset_o,
  input logic          slope2_o,
  input logic          slope3_o,
  input logic          xfer_o,
  input logic          cal_strobe_o,
  input logic [CW-1:0] cnt_w,
  input logic          act_w,
  input logic [NE-1:0] en_l,
  input logic          mode_l
);
  // R1: reset only rises as a result of a frame start
  p_reset_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(pix_reset_o) |-> $past(frame_start, 2));

  // R3: second reset pulse lasts one cycle
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
    slope2_o |=> !slope2_o);

  // R4: second and third pulses need their enables
  p_gate_slope2_r4: assert property (@(posedge clk) disable iff (rst)
    slope2_o |-> $past(en_l[0]));
  p_gate_slope3_r4: assert property (@(posedge clk) disable iff (rst)
    slope3_o |-> $past(en_l[1]));

  // R5: third reset pulse lasts one cycle
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    slope3_o |=> !slope3_o);

  // R6: transfer pulse lasts one cycle
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_o |=> !xfer_o);

  // R8: frame-only calibration strobes only follow a frame start
  p_cal_frame_r8: assert property (@(posedge clk) disable iff (rst)
    (cal_strobe_o && !$past(mode_l)) |-> $past(frame_start, 2));

  // R10: the count never goes down except on frame start
  p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_start) |-> (cnt_w >= $past(cnt_w)));

  // R11: nothing is driven while no frame has started
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !act_w |-> !(pix_reset_o || slope2_o || slope3_o || xfer_o || cal_strobe_o));
endmodule

bind expt_line_timer expt_line_timer_chk #(.CW(CW), .NE(expt_pkg::N_EV)) chk_i (
  .clk(clk), .rst(rst), .frame_start(frame_start),
  .pix_reset_o(pix_reset_o), .slope2_o(slope2_o), .slope3_o(slope3_o),
  .xfer_o(xfer_o), .cal_strobe_o(cal_strobe_o),
  .cnt_w(cnt_w), .act_w(act_w), .en_l(en_l), .mode_l(mode_l)
);

// File: tb/expt_line_timer_tb.sv
`timescale 1ns/1ps
module expt_line_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        line_tick = 1'b0;
  logic [11:0] reset_len_i = 12'd2;
  logic [11:0] slope2_at_i = 12'd2;
  logic [11:0] slope3_at_i = 12'd2;
  logic [11:0] xfer_at_i = 12'd2;
  logic        dual_en_i = 1'b0;
  logic        triple_en_i = 1'b0;
  logic        cal_every_line_i = 1'b1;
  logic        pix_reset_o, slope2_o, slope3_o, xfer_o, cal_strobe_o;

  always #5 clk = ~clk;

  expt_line_timer dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_tick(line_tick),
    .reset_len_i(reset_len_i), .slope2_at_i(slope2_at_i),
    .slope3_at_i(slope3_at_i), .xfer_at_i(xfer_at_i),
    .dual_en_i(dual_en_i), .triple_en_i(triple_en_i),
    .cal_every_line_i(cal_every_line_i),
    .pix_reset_o(pix_reset_o), .slope2_o(slope2_o), .slope3_o(slope3_o),
    .xfer_o(xfer_o), .cal_strobe_o(cal_strobe_o)
  );

  typedef struct {
    int         cyc;
    logic [4:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    ecount = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string tag = "R11";

  // reference state built from the requirements
  bit m_act = 0;
  int m_cnt = 0;
  int m_len = 2;
  int m_t[3];
  bit m_en[3];
  bit m_mode = 1;

  always @(posedge clk) ecount <= ecount + 1;

  function automatic int fl2(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  // outputs packed as {pix_reset, slope2, slope3, xfer, cal}
  task automatic step(input bit fs, input bit lt, input bit r);
    logic [4:0] e;
    bit ev[3];
    bit cal;
    bit inc;
    @(posedge clk); #1;
    rst = r; frame_start = fs; line_tick = lt;
    e = '0;
    if (r) begin
      m_act = 0; m_cnt = 0;
      if (q.size() > 0 && q[$].cyc == ecount + 1) q[$].exp = '0;
    end else begin
      foreach (ev[i]) ev[i] = 0;
      cal = 0;
      if (fs) begin
        m_len = fl2(int'(reset_len_i));
        m_t[0] = fl2(int'(slope2_at_i)); m_en[0] = dual_en_i;
        m_t[1] = fl2(int'(slope3_at_i)); m_en[1] = triple_en_i;
        m_t[2] = fl2(int'(xfer_at_i));   m_en[2] = 1'b1;
        m_mode = cal_every_line_i;
        m_act = 1; m_cnt = 0; cal = 1;
      end else if (lt && m_act) begin
        inc = (m_cnt < 4095);
        if (inc) m_cnt++;
        for (int i = 0; i < 3; i++)
          if (m_en[i] && inc && m_cnt == m_t[i] - 1) ev[i] = 1;
        cal = m_mode;
      end
      e = {(m_act && m_cnt < m_len - 1), ev[0], ev[1], ev[2], cal};
    end
    q.push_back('{ecount + 2, e, tag});
  endtask

  task automatic ticks(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      step(0, 1, 0);
      for (int j = 0; j < gap; j++) step(0, 0, 0);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: compares queued expectations against the outputs
  always @(negedge clk) begin
    logic [4:0] got;
    item_t it;
    if (q.size() > 0 && q[0].cyc == ecount) begin
      it = q.pop_front();
      got = {pix_reset_o, slope2_o, slope3_o, xfer_o, cal_strobe_o};
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s cycle %0d: got %b expected %b", it.tag, ecount, got, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R11: idle after reset, stray ticks ignored
    tag = "R11";
    step(0, 0, 0); step(0, 1, 0); step(0, 0, 0); step(0, 1, 0); step(0, 0, 0);

    // R1 R3 R5 R6 R7: full frame, frame start together with a tick (R11)
    tag = "R1/R3/R5/R6/R7";
    reset_len_i = 12'd5; slope2_at_i = 12'd3; slope3_at_i = 12'd6;
    xfer_at_i = 12'd8; dual_en_i = 1; triple_en_i = 1; cal_every_line_i = 1;
    step(1, 1, 0); step(0, 0, 0);
    ticks(10, 2);

    // R4 R8: enables clear, frame-only calibration
    tag = "R4/R8";
    reset_len_i = 12'd4; slope2_at_i = 12'd3; slope3_at_i = 12'd4;
    xfer_at_i = 12'd5; dual_en_i = 0; triple_en_i = 0; cal_every_line_i = 0;
    step(1, 0, 0); step(0, 0, 0);
    ticks(7, 1);

    // R2: values below the floor
    tag = "R2";
    reset_len_i = 12'd0; slope2_at_i = 12'd0; slope3_at_i = 12'd1;
    xfer_at_i = 12'd1; dual_en_i = 1; triple_en_i = 1; cal_every_line_i = 1;
    step(1, 0, 0); step(0, 0, 0);
    ticks(4, 2);

    // R9: rewrite everything mid-frame
    tag = "R9";
    reset_len_i = 12'd3; slope2_at_i = 12'd5; slope3_at_i = 12'd5;
    xfer_at_i = 12'd4; dual_en_i = 0; triple_en_i = 0; cal_every_line_i = 0;
    step(1, 0, 0); step(0, 0, 0);
    ticks(1, 1);
    reset_len_i = 12'd40; slope2_at_i = 12'd3; xfer_at_i = 12'd2;
    dual_en_i = 1; triple_en_i = 1; cal_every_line_i = 1;
    ticks(8, 1);

    // R10: saturation with late events
    tag = "R10";
    reset_len_i = 12'd4095; slope2_at_i = 12'd4095; slope3_at_i = 12'd3000;
    xfer_at_i = 12'd4095; dual_en_i = 1; triple_en_i = 1; cal_every_line_i = 0;
    step(1, 0, 0); step(0, 0, 0);
    ticks(4200, 1);

    // R11: reset in the middle of a frame silences everything
    tag = "R11";
    reset_len_i = 12'd6; slope2_at_i = 12'd4; xfer_at_i = 12'd5;
    cal_every_line_i = 1;
    step(1, 0, 0); ticks(2, 1);
    step(0, 0, 1); step(0, 1, 1);
    step(0, 0, 0);
    ticks(6, 1);
    repeat (4) step(0, 0, 0);

    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule